// File: doc/BRIEF.md
# AAL5 Segmentation and Reassembly Engine

This block converts between variable-length packets and the fixed 48-byte payloads carried by cells on one virtual circuit. The transmit half takes a packet as a byte stream and emits cell payload bytes. After the last data byte it adds zero padding so that an 8-byte trailer fills the last eight byte slots of the final payload. It flags the last byte of every payload and marks the final payload as the end of the packet. The receive half takes payload bytes, plus the end-of-packet flag from the cell header, and rebuilds the packet. It checks the trailer length and the CRC-32, then delivers only the data bytes, followed by a one-cycle completion strobe that carries a good or bad verdict.

The trailer holds four fields in this order: a user byte, a zero byte, a 16-bit data length sent most significant byte first, and the inverted CRC-32 sent most significant byte first. The CRC uses generator 0x04C11DB7, processed most significant bit first with no reflection, and starts from all ones. It covers the data, the padding and the first four trailer bytes. On receive, data bytes leave through a short delay line. A byte is released as soon as it is certain to be data, and the remainder is released once the length field is known.

Top module: `aal5_sar`

## Requirements
- R1: Every accepted data byte appears on `cell_data_o` with `cell_valid_o` high one cycle after acceptance, in input order.
- R2: After the last data byte of a packet of L bytes, the segmenter emits (40 − L mod 48) mod 48 zero bytes. The whole output for the packet is then a multiple of 48 bytes, and the trailer occupies payload positions 40 to 47 of the final cell.
- R3: The 8 trailer bytes are, in order: the user byte sampled with the last beat, 0x00, length[15:8], length[7:0], then the bitwise inverse of the CRC-32 (generator 0x04C11DB7, MSB-first, initial all ones, over data, pad and these four trailer bytes) from bit 31 down.
- R4: `cell_last_o` is high on every 48th output byte and only there. `cell_eop_o` is high only on byte 47 of the final cell of a packet.
- R5: A beat with `tx_last_i` and `tx_empty_i` both high and no preceding data yields exactly one cell: 40 zero bytes followed by a trailer with length 0.
- R6: For a well-formed packet, the reassembler outputs exactly the number of bytes given by the length field, equal to the first payload bytes in order. It then raises `rx_done_o` for one cycle with `rx_ok_o` high and no data byte in that cycle.
- R7: If the received CRC does not match the CRC computed over all preceding bytes of the packet, including when cells are lost or reordered, the completion carries `rx_ok_o` low.
- R8: With N received bytes, a length field greater than N − 8 or smaller than N − 55 gives `rx_ok_o` low. The boundary values N − 8 and N − 55 are accepted.
- R9: A packet whose length field exceeds 1536, or that reaches a 34th cell, completes with `rx_ok_o` low. Further cells are discarded until a cell with the end flag set, and reception of the next packet then proceeds normally.
- R10: A single end-flagged cell with a length field of 0 and a valid CRC completes with `rx_ok_o` high and no data bytes.
- R11: After reset, `tx_ready_o` and `rx_cell_ready_o` are high, and `cell_valid_o`, `rx_valid_o` and `rx_done_o` are low.
- R12: `tx_ready_o` is low for exactly pad + 8 cycles after the last beat of a packet is accepted, and high otherwise while the segmenter is idle or taking data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit beat present |
| tx_ready_o | output | 1 | Segmenter accepts a beat this cycle |
| tx_data_i | input | 8 | Transmit data byte |
| tx_last_i | input | 1 | Beat ends the packet |
| tx_empty_i | input | 1 | Beat carries no data byte (zero-length end) |
| tx_uu_i | input | 8 | User byte for the trailer, sampled with the last beat |
| cell_valid_o | output | 1 | Payload byte valid |
| cell_data_o | output | 8 | Payload byte |
| cell_last_o | output | 1 | Byte 47 of a payload |
| cell_eop_o | output | 1 | Byte 47 of the final payload of a packet |
| rx_cell_valid_i | input | 1 | Received payload byte present |
| rx_cell_ready_o | output | 1 | Reassembler accepts a payload byte |
| rx_cell_data_i | input | 8 | Received payload byte |
| rx_cell_eop_i | input | 1 | End-of-packet header flag, sampled with byte 47 |
| rx_valid_o | output | 1 | Reassembled data byte valid |
| rx_data_o | output | 8 | Reassembled data byte |
| rx_done_o | output | 1 | One-cycle packet completion strobe |
| rx_ok_o | output | 1 | Verdict for the completion, valid with rx_done_o |

## Verification
If the segmenter's position counter or state drifts, the error shows at the ports within one cell. `cell_last_o` falls off the 48-byte grid, or the trailer lands away from slots 40 to 47, and the byte-by-byte comparison of the next packet catches either case. Corrupted receive state shows on the next completion strobe. A wrong delay-line fill or release count gives a delivered byte count that differs from the length field. A wrong CRC snapshot or length capture turns a good verdict bad. A stuck discard state suppresses the strobe for the following good packet.

// File: rtl/aal5_pkg.sv
package aal5_pkg;
  localparam int unsigned TRL_BYTES = 8;
  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT  = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {S_DATA, S_PAD, S_TRL} seg_state_e;
  typedef enum logic [1:0] {R_RECV, R_DROP, R_DRAIN, R_DONE} rsm_state_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/aal5_crc32_byte.sv
module aal5_crc32_byte
  import aal5_pkg::*;
(
  input  logic [31:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  always_comb crc_o = crc32_step(crc_i, data_i);
endmodule

// File: rtl/aal5_seg.sv
module aal5_seg
  import aal5_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  input  logic [7:0] tx_data_i,
  input  logic       tx_last_i,
  input  logic       tx_empty_i,
  input  logic [7:0] tx_uu_i,
  output logic       cell_valid_o,
  output logic [7:0] cell_data_o,
  output logic       cell_last_o,
  output logic       cell_eop_o
);
  localparam int unsigned IW = $clog2(CELL_BYTES);
  localparam logic [IW-1:0] LAST_POS = IW'(CELL_BYTES - 1);
  localparam logic [IW-1:0] TRL_POS  = IW'(CELL_BYTES - TRL_BYTES);

  seg_state_e    state_q;
  logic [IW-1:0] idx_q, idx_nx;
  logic [15:0]   len_q;
  logic [31:0]   crc_q, crc_upd, crc_inv;
  logic [2:0]    tcnt_q;
  logic [7:0]    uu_q, byte_d;
  logic          emit;

  assign idx_nx     = (idx_q == LAST_POS) ? '0 : idx_q + 1'b1;
  assign tx_ready_o = (state_q == S_DATA);
  assign crc_inv    = ~crc_q;
  assign emit       = (state_q == S_DATA) ? (tx_valid_i && !tx_empty_i) : 1'b1;

  always_comb begin
    byte_d = 8'h00;
    unique case (state_q)
      S_DATA: byte_d = tx_data_i;
      S_PAD:  byte_d = 8'h00;
      default: begin
        unique case (tcnt_q)
          3'd0: byte_d = uu_q;
          3'd1: byte_d = 8'h00;
          3'd2: byte_d = len_q[15:8];
          3'd3: byte_d = len_q[7:0];
          3'd4: byte_d = crc_inv[31:24];
          3'd5: byte_d = crc_inv[23:16];
          3'd6: byte_d = crc_inv[15:8];
          default: byte_d = crc_inv[7:0];
        endcase
      end
    endcase
  end

  aal5_crc32_byte u_crc (.crc_i(crc_q), .data_i(byte_d), .crc_o(crc_upd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_DATA;
      idx_q        <= '0;
      len_q        <= '0;
      crc_q        <= CRC_INIT;
      tcnt_q       <= '0;
      uu_q         <= '0;
      cell_valid_o <= 1'b0;
      cell_data_o  <= '0;
      cell_last_o  <= 1'b0;
      cell_eop_o   <= 1'b0;
    end else begin
      cell_valid_o <= emit;
      cell_last_o  <= emit && (idx_q == LAST_POS);
      cell_eop_o   <= (state_q == S_TRL) && (tcnt_q == 3'd7);
      if (emit) begin
        cell_data_o <= byte_d;
        idx_q       <= idx_nx;
      end
      unique case (state_q)
        S_DATA: if (tx_valid_i) begin
          if (!tx_empty_i) begin
            crc_q <= crc_upd;
            len_q <= len_q + 1'b1;
          end
          if (tx_last_i) begin
            uu_q   <= tx_uu_i;
            tcnt_q <= '0;
            if ((tx_empty_i ? idx_q : idx_nx) == TRL_POS) state_q <= S_TRL;
            else state_q <= S_PAD;
          end
        end
        S_PAD: begin
          crc_q <= crc_upd;
          if (idx_nx == TRL_POS) state_q <= S_TRL;
        end
        default: begin
          if (!tcnt_q[2]) crc_q <= crc_upd;
          tcnt_q <= tcnt_q + 1'b1;
          if (tcnt_q == 3'd7) begin
            state_q <= S_DATA;
            crc_q   <= CRC_INIT;
            len_q   <= '0;
          end
        end
      endcase
    end
  end

  p_eop_on_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_eop_o |-> (cell_last_o && cell_valid_o));
  p_trl_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TRL) |-> (idx_q >= TRL_POS));
  p_pad_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PAD) |=> (cell_valid_o && cell_data_o == 8'h00));
endmodule

// File: rtl/aal5_reasm.sv
module aal5_reasm
  import aal5_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 48,
  parameter int unsigned MAX_LEN    = 1536,
  parameter int unsigned DLY_DEPTH  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_cell_valid_i,
  output logic       rx_cell_ready_o,
  input  logic [7:0] rx_cell_data_i,
  input  logic       rx_cell_eop_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_data_o,
  output logic       rx_done_o,
  output logic       rx_ok_o
);
  localparam int unsigned IW        = $clog2(CELL_BYTES);
  localparam int unsigned AW        = $clog2(DLY_DEPTH);
  localparam int unsigned TAIL      = CELL_BYTES - 1 + TRL_BYTES;
  localparam int unsigned MAX_CELLS = (MAX_LEN + TRL_BYTES + CELL_BYTES - 1) / CELL_BYTES;
  localparam int unsigned CW        = $clog2(MAX_CELLS + 1);
  localparam logic [IW-1:0] LAST_POS = IW'(CELL_BYTES - 1);
  localparam logic [IW-1:0] LHI_POS  = IW'(CELL_BYTES - 6);
  localparam logic [IW-1:0] LLO_POS  = IW'(CELL_BYTES - 5);
  localparam logic [AW:0]   TAIL_F   = (AW+1)'(TAIL);

  rsm_state_e    state_q;
  logic [IW-1:0] idx_q, idx_nx;
  logic [CW-1:0] cells_q;
  logic [15:0]   nrx_q, rel_q, len_q, left_q, n_f, rel_f;
  logic [7:0]    lhi_q;
  logic [31:0]   crc_q, crc_upd, crc_snap_q;
  logic [23:0]   rcv_q;
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   fill_q;
  logic          ok_q, take, pop_rx, crc_ok, bad;
  logic [16:0]   len_ext;
  logic [7:0]    mem_q [DLY_DEPTH];

  assign rx_cell_ready_o = (state_q == R_RECV) || (state_q == R_DROP);
  assign take    = rx_cell_ready_o && rx_cell_valid_i;
  assign idx_nx  = (idx_q == LAST_POS) ? '0 : idx_q + 1'b1;
  assign pop_rx  = (state_q == R_RECV) && take && (fill_q == TAIL_F);
  assign n_f     = nrx_q + 1'b1;
  assign rel_f   = rel_q + {15'd0, pop_rx};
  assign crc_ok  = (~crc_snap_q) == {rcv_q, rx_cell_data_i};
  assign len_ext = {1'b0, len_q} + 17'(TAIL);
  assign bad     = !crc_ok || (len_q > n_f - 16'(TRL_BYTES)) ||
                   (len_ext < {1'b0, n_f}) || (len_q > 16'(MAX_LEN));

  aal5_crc32_byte u_crc (.crc_i(crc_q), .data_i(rx_cell_data_i), .crc_o(crc_upd));

  always_ff @(posedge clk_i)
    if (state_q == R_RECV && take) mem_q[wr_q] <= rx_cell_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= R_RECV;
      idx_q      <= '0;
      cells_q    <= '0;
      nrx_q      <= '0;
      rel_q      <= '0;
      len_q      <= '0;
      left_q     <= '0;
      lhi_q      <= '0;
      crc_q      <= CRC_INIT;
      crc_snap_q <= '0;
      rcv_q      <= '0;
      wr_q       <= '0;
      rd_q       <= '0;
      fill_q     <= '0;
      ok_q       <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      rx_done_o  <= 1'b0;
      rx_ok_o    <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      rx_done_o  <= 1'b0;
      unique case (state_q)
        R_RECV: if (take) begin
          idx_q <= idx_nx;
          nrx_q <= n_f;
          crc_q <= crc_upd;
          wr_q  <= wr_q + 1'b1;
          if (pop_rx) begin
            rx_valid_o <= 1'b1;
            rx_data_o  <= mem_q[rd_q];
            rd_q       <= rd_q + 1'b1;
            rel_q      <= rel_f;
          end else begin
            fill_q <= fill_q + 1'b1;
          end
          if (idx_q == LHI_POS) lhi_q <= rx_cell_data_i;
          if (idx_q == LLO_POS) begin
            len_q      <= {lhi_q, rx_cell_data_i};
            crc_snap_q <= crc_upd;
          end
          if (idx_q > LLO_POS) rcv_q <= {rcv_q[15:0], rx_cell_data_i};
          if (idx_q == LAST_POS) begin
            if (rx_cell_eop_i) begin
              ok_q    <= !bad;
              left_q  <= len_q - rel_f;
              state_q <= bad ? R_DONE : R_DRAIN;
            end else begin
              cells_q <= cells_q + 1'b1;
              if (cells_q + 1'b1 == CW'(MAX_CELLS)) state_q <= R_DROP;
            end
          end
        end
        R_DROP: if (take) begin
          idx_q <= idx_nx;
          if (idx_q == LAST_POS && rx_cell_eop_i) begin
            ok_q    <= 1'b0;
            state_q <= R_DONE;
          end
        end
        R_DRAIN: begin
          if (left_q != '0) begin
            rx_valid_o <= 1'b1;
            rx_data_o  <= mem_q[rd_q];
            rd_q       <= rd_q + 1'b1;
            fill_q     <= fill_q - 1'b1;
            left_q     <= left_q - 1'b1;
          end else begin
            state_q <= R_DONE;
          end
        end
        default: begin
          rx_done_o <= 1'b1;
          rx_ok_o   <= ok_q;
          state_q   <= R_RECV;
          idx_q     <= '0;
          cells_q   <= '0;
          nrx_q     <= '0;
          rel_q     <= '0;
          crc_q     <= CRC_INIT;
          wr_q      <= '0;
          rd_q      <= '0;
          fill_q    <= '0;
        end
      endcase
    end
  end

  p_dly_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= TAIL_F);
  p_drain_fits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == R_DRAIN) |-> (left_q <= 16'(fill_q)));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);
  p_done_alone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> !rx_valid_o);
  p_drop_bad_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == R_DROP && take && idx_q == LAST_POS && rx_cell_eop_i)
      |=> ##1 (rx_done_o && !rx_ok_o));
endmodule

// File: rtl/aal5_sar.sv
module aal5_sar
  import aal5_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 48,
  parameter int unsigned MAX_LEN    = 1536,
  parameter int unsigned DLY_DEPTH  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  input  logic [7:0] tx_data_i,
  input  logic       tx_last_i,
  input  logic       tx_empty_i,
  input  logic [7:0] tx_uu_i,
  output logic       cell_valid_o,
  output logic [7:0] cell_data_o,
  output logic       cell_last_o,
  output logic       cell_eop_o,
  input  logic       rx_cell_valid_i,
  output logic       rx_cell_ready_o,
  input  logic [7:0] rx_cell_data_i,
  input  logic       rx_cell_eop_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_data_o,
  output logic       rx_done_o,
  output logic       rx_ok_o
);
  aal5_seg #(.CELL_BYTES(CELL_BYTES)) u_seg (
    .clk_i, .rst_ni, .tx_valid_i, .tx_ready_o, .tx_data_i, .tx_last_i,
    .tx_empty_i, .tx_uu_i, .cell_valid_o, .cell_data_o, .cell_last_o, .cell_eop_o
  );

  aal5_reasm #(.CELL_BYTES(CELL_BYTES), .MAX_LEN(MAX_LEN), .DLY_DEPTH(DLY_DEPTH)) u_reasm (
    .clk_i, .rst_ni, .rx_cell_valid_i, .rx_cell_ready_o, .rx_cell_data_i,
    .rx_cell_eop_i, .rx_valid_o, .rx_data_o, .rx_done_o, .rx_ok_o
  );
endmodule

// File: tb/aal5_sar_tb_top.sv
`timescale 1ns/1ps
module aal5_sar_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_valid = 0, tx_last = 0, tx_empty = 0;
  logic [7:0] tx_data = 0, tx_uu = 0;
  logic rx_cv = 0, rx_ceop = 0;
  logic [7:0] rx_cd = 0;
  logic tx_ready, cell_valid, cell_last, cell_eop, rx_cready, rx_valid, rx_done, rx_ok;
  logic [7:0] cell_data, rx_data;

  always #2 clk = ~clk;

  aal5_sar dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .tx_last_i(tx_last), .tx_empty_i(tx_empty), .tx_uu_i(tx_uu),
    .cell_valid_o(cell_valid), .cell_data_o(cell_data),
    .cell_last_o(cell_last), .cell_eop_o(cell_eop),
    .rx_cell_valid_i(rx_cv), .rx_cell_ready_o(rx_cready),
    .rx_cell_data_i(rx_cd), .rx_cell_eop_i(rx_ceop),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_done_o(rx_done), .rx_ok_o(rx_ok)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] pkt [0:2047];
  logic [7:0] cel [0:2047];
  int cn = 0, cur_pad = 0;
  logic [7:0] scap [0:2047];
  bit slast [0:2047];
  bit seop [0:2047];
  int sn = 0, nrdy = 0;
  logic [7:0] rcap [0:2047];
  int rn = 0, done_cnt = 0;
  bit last_ok = 0;

  task automatic chk(bit cond, string req, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (cell_valid && sn < 2048) begin
      scap[sn] = cell_data; slast[sn] = cell_last; seop[sn] = cell_eop; sn++;
    end
    if (!tx_ready) nrdy++;
    if (rx_valid && rn < 2048) begin rcap[rn] = rx_data; rn++; end
    if (rx_done) begin done_cnt++; last_ok = rx_ok; end
  end

  function automatic logic [31:0] crc_b(logic [31:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[31] ^ d[7-i];
      c = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  // Expected cell stream: data, zero pad to slot 40, trailer with given length field.
  task automatic build(int len, int lfield, logic [7:0] uu);
    logic [31:0] c;
    for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
    cn = 0;
    for (int i = 0; i < len; i++) begin cel[cn] = pkt[i]; cn++; end
    cur_pad = (40 - (len % 48) + 48) % 48;
    for (int i = 0; i < cur_pad; i++) begin cel[cn] = 8'h00; cn++; end
    cel[cn] = uu; cel[cn+1] = 8'h00; cel[cn+2] = 8'(lfield >> 8); cel[cn+3] = 8'(lfield);
    cn += 4;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < cn; i++) c = crc_b(c, cel[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) begin cel[cn] = c[31-8*i -: 8]; cn++; end
  endtask

  task automatic run_seg(int len, logic [7:0] uu, string req);
    int mis = 0, fmis = 0, t = 0;
    build(len, len, uu);
    @(negedge clk); sn = 0; nrdy = 0;
    if (len == 0) begin
      tx_valid = 1; tx_empty = 1; tx_last = 1; tx_uu = uu;
      @(negedge clk);
    end else begin
      for (int i = 0; i < len; i++) begin
        if ($urandom % 5 == 0) begin tx_valid = 0; @(negedge clk); end
        while (!tx_ready) @(negedge clk);
        tx_valid = 1; tx_empty = 0; tx_data = pkt[i]; tx_last = (i == len - 1); tx_uu = uu;
        @(negedge clk);
      end
    end
    tx_valid = 0; tx_last = 0; tx_empty = 0;
    while (sn < cn && t < 4000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(sn == cn, {req, " R2 cell byte count"}, sn, cn);
    for (int i = 0; i < cn && i < sn; i++) begin
      if (scap[i] !== cel[i]) mis++;
      if (slast[i] != (i % 48 == 47) || seop[i] != (i == cn - 1)) fmis++;
    end
    chk(mis == 0, {req, " R1 R3 payload bytes"}, mis, 0);
    chk(fmis == 0, {req, " R4 last/eop flags"}, fmis, 0);
    chk(nrdy == cur_pad + 8, {req, " R12 ready low cycles"}, nrdy, cur_pad + 8);
  endtask

  task automatic feed_rx(int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      if ($urandom % 6 == 0) begin rx_cv = 0; @(negedge clk); end
      while (!rx_cready) @(negedge clk);
      rx_cv = 1; rx_cd = cel[i]; rx_ceop = (i == nbytes - 1);
      @(negedge clk);
    end
    rx_cv = 0; rx_ceop = 0;
  endtask

  task automatic run_rx(bit exp_ok, int exp_len, string req);
    int d0, t = 0, mis = 0;
    @(negedge clk); rn = 0; d0 = done_cnt;
    feed_rx(cn);
    while (done_cnt == d0 && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, {req, " completion strobes"}, done_cnt - d0, 1);
    chk(last_ok == exp_ok, {req, " verdict"}, int'(last_ok), int'(exp_ok));
    if (exp_ok) begin
      chk(rn == exp_len, {req, " R6 delivered byte count"}, rn, exp_len);
      for (int i = 0; i < rn && i < exp_len; i++) if (rcap[i] !== cel[i]) mis++;
      chk(mis == 0, {req, " R6 delivered bytes"}, mis, 0);
    end
  endtask

  initial begin
    logic [7:0] tmp;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(tx_ready == 1, "R11 tx_ready after reset", tx_ready, 1);
    chk(rx_cready == 1, "R11 rx_cell_ready after reset", rx_cready, 1);
    chk(cell_valid == 0, "R11 cell_valid after reset", cell_valid, 0);
    chk(rx_valid == 0 && rx_done == 0, "R11 rx outputs after reset", rx_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R5 / R10: zero-length
    run_seg(0, 8'h5A, "len0 R5");
    chk(cn == 48, "R5 single cell", cn, 48);
    run_rx(1, 0, "len0 R10");
    // Directed boundaries of padding
    run_seg(40, 8'h01, "len40"); run_rx(1, 40, "len40");
    run_seg(41, 8'h02, "len41"); run_rx(1, 41, "len41");
    run_seg(47, 8'h03, "len47"); run_rx(1, 47, "len47");
    run_seg(48, 8'h04, "len48"); run_rx(1, 48, "len48");
    run_seg(88, 8'h05, "len88"); run_rx(1, 88, "len88");
    run_seg(1536, 8'h06, "len1536"); run_rx(1, 1536, "len1536 R6");
    // Random lengths
    for (int k = 0; k < 8; k++) begin
      int l = 1 + ($urandom % 400);
      run_seg(l, 8'($urandom), "random");
      run_rx(1, l, "random R6");
    end
    // R7: corrupted byte, then swapped cells
    build(100, 100, 8'h10); cel[10] = cel[10] ^ 8'h01;
    run_rx(0, 0, "R7 corrupt byte");
    build(200, 200, 8'h11);
    for (int i = 0; i < 48; i++) begin tmp = cel[i]; cel[i] = cel[48+i]; cel[48+i] = tmp; end
    run_rx(0, 0, "R7 swapped cells");
    // R8: length bounds with N=144
    build(100, 150, 8'h12); run_rx(0, 0, "R8 length too large");
    build(100, 30, 8'h13);  run_rx(0, 0, "R8 length too small");
    build(100, 89, 8'h14);  run_rx(1, 89, "R8 lower bound N-55");
    build(100, 136, 8'h15); run_rx(1, 136, "R8 upper bound N-8");
    // R9: oversize
    build(1600, 1600, 8'h16); run_rx(0, 0, "R9 34 cells");
    build(1540, 1540, 8'h17); run_rx(0, 0, "R9 length over limit");
    build(60, 60, 8'h18); run_rx(1, 60, "R9 recovery");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule